// File: doc/BRIEF.md
# Flash Pulse Timing Controller

This block decides when a camera flash LED driver may fire and for how long. A flash can start in two ways. Software can write a rising transition on a flash request bit, or an external strobe pin can start it. The strobe is asynchronous and is resynchronised inside the block. It can act on its rising edge, or it can hold the flash on for as long as it stays high, up to a programmed limit. Every flash is capped by a 4-bit duration code. The block counts the cap in ticks of a 1 ms strobe that comes from elsewhere on the chip.

A new flash is accepted only when two conditions hold. The storage capacitor must report end of charge, unless a bypass bit is set. The ambient-sense comparators, when they are enabled, must not report the high region. The middle ambient region lowers the effective current-level code to the 70 % code. When a flash ends, the block gives a one-cycle completion pulse. If software started the flash, it also gives a request to clear the flash and torch register bits. The analog regulation, the comparators and the charger sit outside this block and arrive here as digital levels.

Top module: `flash_pulse_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, flash_on, flash_done and clr_mode_req are all 0.
- R2: The cap in 1 ms ticks is 16 × (code + 1) for dur_code 0 to 14, and 512 for dur_code 15. A timed flash stays on for exactly that many ticks.
- R3: With strobe_level_sel = 0, a rising edge on strobe_pin starts a flash of the full cap length, however long the pin stays high. The edge is seen after a two-flop synchroniser, so the flash starts three clock edges after the pin rises.
- R4: With strobe_level_sel = 1, a flash started by the strobe ends when the synchronised pin goes low or when the cap expires, whichever comes first. A flash started by software is always timed.
- R5: A 0-to-1 transition on sw_flash_bit starts a flash on the next clock edge. When that flash ends, clr_mode_req pulses in the same cycle as flash_done. A flash started by the strobe never raises clr_mode_req.
- R6: When charge_gate_bypass = 0, a trigger is accepted only if eoc_flag = 1 in the accepting cycle. A refused trigger gives no flash_on and no flash_done. When charge_gate_bypass = 1, eoc_flag is ignored.
- R7: When amb_sense_en = 1 and amb_zone is 2'b10 or 2'b11 (the high region), triggers are refused with no pulse and no completion. When amb_sense_en = 0, amb_zone has no effect.
- R8: eff_level equals prog_level, except when amb_sense_en = 1, amb_zone = 2'b01 (the middle region) and prog_level > 4. In that case eff_level is 4, the 70 % code. Code n stands for (n + 3) × 10 % of full scale. amb_zone = 2'b00 is the low region.
- R9: A trigger that arrives while a flash is on is ignored. This includes a trigger in the very cycle in which the flash ends. The cap is not restarted, and only one flash_done results.
- R10: flash_done is high for exactly one cycle, namely the first cycle in which flash_on is low again after a flash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| strobe_pin | input | 1 | Asynchronous external flash trigger |
| strobe_level_sel | input | 1 | 0: edge sensitive, 1: level sensitive |
| sw_flash_bit | input | 1 | Software flash request bit; its rising transition triggers |
| dur_code | input | 4 | Duration cap code |
| charge_gate_bypass | input | 1 | 1 lets a flash start without end of charge |
| eoc_flag | input | 1 | End-of-charge reached |
| amb_sense_en | input | 1 | Enables ambient throttling |
| amb_zone | input | 2 | Ambient region: 00 low, 01 middle, 1x high |
| prog_level | input | 3 | Programmed flash current-level code |
| flash_on | output | 1 | Flash enable to the current driver |
| eff_level | output | 3 | Current-level code after ambient limiting |
| flash_done | output | 1 | One-cycle completion pulse |
| clr_mode_req | output | 1 | Request to clear the flash and torch bits |

## Verification
Two functions can meet in one cycle: the ending of a flash at its last tick, and the acceptance of a new software trigger. The bench tracks the ticks it has fed to a running flash. In the cycle whose tick ends the flash, it raises the request bit. It then expects no second flash and a single completion. In a second run it raises the bit one cycle later and expects a fresh flash to start. In level mode the strobe release and the cap expiry compete in the same way. That case is judged by whether the flash ends early, with a tick count below the cap, or at the cap.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   typedef enum logic [1:0] {
      AMB_LOW   = 2'b00,
      AMB_MID   = 2'b01,
      AMB_HIGH  = 2'b10,
      AMB_HIGH2 = 2'b11
   } amb_zone_e;

   typedef enum logic {
      FIRE_IDLE = 1'b0,
      FIRE_ON   = 1'b1
   } fire_state_e;
endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fpc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fpc_timeout.sv
module fpc_timeout #(
   parameter int CODE_W    = 4,
   parameter int STEP_MS   = 16,
   parameter int LONG_MS   = 512,
   parameter bit LONG_LAST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   output logic              expire
);
   localparam int LIN_MAX = STEP_MS * (2 ** CODE_W);
   localparam int TOP_MS  = (LONG_MS > LIN_MAX) ? LONG_MS : LIN_MAX;
   localparam int CNT_W   = $clog2(TOP_MS + 1);

   if (STEP_MS < 1 || LONG_MS < 1) begin : g_bad_step
      $error("fpc_timeout: STEP_MS and LONG_MS must be positive");
   end
   if (CNT_W < CODE_W) begin : g_bad_width
      $error("fpc_timeout: counter narrower than code");
   end

   logic [CNT_W-1:0] lim_next, lim_q, cnt_q;
   logic [CNT_W-1:0] linear_lim;

   assign linear_lim = CNT_W'(STEP_MS) * (CNT_W'(code) + CNT_W'(1));

   if (LONG_LAST) begin : g_long_last
      always_comb lim_next = (&code) ? CNT_W'(LONG_MS) : linear_lim;
   end else begin : g_linear
      always_comb lim_next = linear_lim;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (start) begin
         cnt_q <= '0;
         lim_q <= lim_next;
      end else if (run && tick) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign expire = run && tick && (cnt_q == lim_q - CNT_W'(1));

   p_cnt_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < lim_q));

   p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/fpc_level_limit.sv
module fpc_level_limit
   import fpc_pkg::*;
#(
   parameter int LVL_W    = 3,
   parameter int CAP_CODE = 4
) (
   input  logic             amb_en,
   input  amb_zone_e        zone,
   input  logic [LVL_W-1:0] prog,
   output logic [LVL_W-1:0] eff
);
   localparam logic [LVL_W-1:0] CAP = LVL_W'(CAP_CODE);

   if (CAP_CODE < 0 || CAP_CODE >= (2 ** LVL_W)) begin : g_bad_cap
      $error("fpc_level_limit: CAP_CODE outside code range");
   end

   always_comb begin
      eff = prog;
      if (amb_en && zone == AMB_MID && prog > CAP) eff = CAP;
   end
endmodule

// File: rtl/flash_pulse_ctrl.sv
module flash_pulse_ctrl
   import fpc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DUR_W       = 4,
   parameter int STEP_MS     = 16,
   parameter int LONG_MS     = 512,
   parameter int LVL_W       = 3,
   parameter int MID_CAP     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_1ms,
   input  logic             strobe_pin,
   input  logic             strobe_level_sel,
   input  logic             sw_flash_bit,
   input  logic [DUR_W-1:0] dur_code,
   input  logic             charge_gate_bypass,
   input  logic             eoc_flag,
   input  logic             amb_sense_en,
   input  logic [1:0]       amb_zone,
   input  logic [LVL_W-1:0] prog_level,
   output logic             flash_on,
   output logic [LVL_W-1:0] eff_level,
   output logic             flash_done,
   output logic             clr_mode_req
);
   logic        strobe_s, strobe_q, sw_q;
   logic        strobe_rise, sw_rise, trig, ready, amb_block, accept;
   logic        expire, release_pin, end_now;
   fire_state_e fire_q;
   logic        src_sw_q, pin_hold_q, done_q, clr_q;
   amb_zone_e   zone;

   assign zone = amb_zone_e'(amb_zone);

   fpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(strobe_pin), .q_sync(strobe_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         sw_q     <= 1'b0;
      end else begin
         strobe_q <= strobe_s;
         sw_q     <= sw_flash_bit;
      end
   end

   assign strobe_rise = strobe_s & ~strobe_q;
   assign sw_rise     = sw_flash_bit & ~sw_q;
   assign trig        = strobe_rise | sw_rise;
   assign ready       = charge_gate_bypass | eoc_flag;
   assign amb_block   = amb_sense_en && (zone == AMB_HIGH || zone == AMB_HIGH2);
   assign accept      = (fire_q == FIRE_IDLE) && trig && ready && !amb_block;

   fpc_timeout #(
      .CODE_W(DUR_W), .STEP_MS(STEP_MS), .LONG_MS(LONG_MS), .LONG_LAST(1'b1)
   ) u_timeout (
      .clk(clk), .rst_n(rst_n), .start(accept), .run(fire_q == FIRE_ON),
      .tick(tick_1ms), .code(dur_code), .expire(expire)
   );

   assign release_pin = pin_hold_q && !strobe_s;
   assign end_now     = (fire_q == FIRE_ON) && (expire || release_pin);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fire_q     <= FIRE_IDLE;
         src_sw_q   <= 1'b0;
         pin_hold_q <= 1'b0;
         done_q     <= 1'b0;
         clr_q      <= 1'b0;
      end else begin
         done_q <= end_now;
         clr_q  <= end_now && src_sw_q;
         if (accept) begin
            fire_q     <= FIRE_ON;
            src_sw_q   <= sw_rise;
            pin_hold_q <= strobe_level_sel && !sw_rise;
         end else if (end_now) begin
            fire_q     <= FIRE_IDLE;
            pin_hold_q <= 1'b0;
         end
      end
   end

   assign flash_on     = (fire_q == FIRE_ON);
   assign flash_done   = done_q;
   assign clr_mode_req = clr_q;

   fpc_level_limit #(.LVL_W(LVL_W), .CAP_CODE(MID_CAP)) u_level (
      .amb_en(amb_sense_en), .zone(zone), .prog(prog_level), .eff(eff_level)
   );

   p_gate_needs_eoc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flash_on) |-> $past(charge_gate_bypass || eoc_flag));

   p_high_zone_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flash_on) |-> !$past(amb_sense_en && amb_zone[1]));

   p_mid_zone_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (amb_sense_en && amb_zone == 2'b01) |-> (eff_level <= LVL_W'(MID_CAP)));

   p_done_after_flash_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flash_done |-> (!flash_on && $past(flash_on)));

   p_fall_gives_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flash_on) |-> flash_done);

   p_clr_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_mode_req |-> flash_done);
endmodule

// File: tb/flash_pulse_ctrl_bench.sv
module flash_pulse_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 8;
   localparam int NVEC       = 12;

   typedef struct packed {
      logic       use_sw;
      logic       lvl_mode;
      logic [3:0] dur;
      logic       bypass;
      logic       eoc;
      logic       amb_en;
      logic [1:0] zone;
      logic [2:0] code;
      logic [9:0] exp_ticks;
      logic [2:0] exp_lvl;
      logic       exp_clr;
   } vec_t;

   // fields: sw, level, dur, bypass, eoc, amb_en, zone, prog, ticks, eff, clr
   localparam vec_t VEC [0:NVEC-1] = '{
      '{1'b1, 1'b0, 4'd0,  1'b0, 1'b1, 1'b0, 2'b00, 3'd7, 10'd16,  3'd7, 1'b1},
      '{1'b0, 1'b0, 4'd1,  1'b0, 1'b1, 1'b0, 2'b00, 3'd5, 10'd32,  3'd5, 1'b0},
      '{1'b1, 1'b0, 4'd5,  1'b0, 1'b1, 1'b1, 2'b00, 3'd7, 10'd96,  3'd7, 1'b1},
      '{1'b0, 1'b0, 4'd14, 1'b0, 1'b1, 1'b1, 2'b01, 3'd7, 10'd240, 3'd4, 1'b0},
      '{1'b1, 1'b0, 4'd15, 1'b0, 1'b1, 1'b1, 2'b01, 3'd3, 10'd512, 3'd3, 1'b1},
      '{1'b1, 1'b0, 4'd2,  1'b0, 1'b0, 1'b0, 2'b00, 3'd6, 10'd0,   3'd6, 1'b0},
      '{1'b0, 1'b0, 4'd2,  1'b1, 1'b0, 1'b0, 2'b00, 3'd6, 10'd48,  3'd6, 1'b0},
      '{1'b1, 1'b0, 4'd3,  1'b0, 1'b1, 1'b1, 2'b10, 3'd7, 10'd0,   3'd7, 1'b0},
      '{1'b0, 1'b0, 4'd3,  1'b0, 1'b1, 1'b1, 2'b11, 3'd2, 10'd0,   3'd2, 1'b0},
      '{1'b1, 1'b0, 4'd4,  1'b0, 1'b1, 1'b0, 2'b10, 3'd1, 10'd80,  3'd1, 1'b1},
      '{1'b1, 1'b1, 4'd0,  1'b0, 1'b1, 1'b0, 2'b00, 3'd0, 10'd16,  3'd0, 1'b1},
      '{1'b0, 1'b1, 4'd1,  1'b0, 1'b1, 1'b0, 2'b00, 3'd7, 10'd32,  3'd7, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1ms = 1'b0;
   logic       strobe_pin = 1'b0;
   logic       strobe_level_sel = 1'b0;
   logic       sw_flash_bit = 1'b0;
   logic [3:0] dur_code = '0;
   logic       charge_gate_bypass = 1'b0;
   logic       eoc_flag = 1'b0;
   logic       amb_sense_en = 1'b0;
   logic [1:0] amb_zone = '0;
   logic [2:0] prog_level = '0;
   logic       flash_on, flash_done, clr_mode_req;
   logic [2:0] eff_level;

   int n_checks = 0;
   int n_fail   = 0;
   int phase    = 0;
   int ticks_seen = 0;
   int done_seen  = 0;
   int clr_seen   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_pulse_ctrl u_flash_pulse_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .strobe_pin(strobe_pin),
      .strobe_level_sel(strobe_level_sel), .sw_flash_bit(sw_flash_bit),
      .dur_code(dur_code), .charge_gate_bypass(charge_gate_bypass),
      .eoc_flag(eoc_flag), .amb_sense_en(amb_sense_en), .amb_zone(amb_zone),
      .prog_level(prog_level), .flash_on(flash_on), .eff_level(eff_level),
      .flash_done(flash_done), .clr_mode_req(clr_mode_req)
   );

   task automatic cyc();
      @(negedge clk);
      tick_1ms = (phase == TICK_DIV - 1);
      phase = (phase == TICK_DIV - 1) ? 0 : phase + 1;
      if (flash_on && tick_1ms) ticks_seen++;
      if (flash_done) done_seen++;
      if (clr_mode_req) clr_seen++;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_counts();
      ticks_seen = 0; done_seen = 0; clr_seen = 0;
   endtask

   task automatic wait_done(input int limit);
      for (int n = 0; n < limit && done_seen == 0; n++) cyc();
   endtask

   initial begin
      repeat (4) cyc();
      chk(flash_on == 1'b0, "R1 flash_on in reset", int'(flash_on), 0);
      rst_n = 1'b1;
      cyc();
      chk(flash_done == 1'b0, "R1 flash_done after reset", int'(flash_done), 0);
      chk(clr_mode_req == 1'b0, "R1 clr_mode_req after reset", int'(clr_mode_req), 0);
      chk(flash_on == 1'b0, "R1 flash_on after reset", int'(flash_on), 0);

      for (int v = 0; v < NVEC; v++) begin
         strobe_level_sel   = VEC[v].lvl_mode;
         dur_code           = VEC[v].dur;
         charge_gate_bypass = VEC[v].bypass;
         eoc_flag           = VEC[v].eoc;
         amb_sense_en       = VEC[v].amb_en;
         amb_zone           = VEC[v].zone;
         prog_level         = VEC[v].code;
         repeat (6) cyc();
         clear_counts();
         chk(eff_level == VEC[v].exp_lvl, $sformatf("R8 eff_level vec %0d", v),
             int'(eff_level), int'(VEC[v].exp_lvl));
         if (VEC[v].use_sw) sw_flash_bit = 1'b1; else strobe_pin = 1'b1;
         if (VEC[v].exp_ticks == 0) repeat (100) cyc();
         else wait_done(6000);
         sw_flash_bit = 1'b0; strobe_pin = 1'b0;
         repeat (8) cyc();
         chk(ticks_seen == int'(VEC[v].exp_ticks),
             $sformatf("R2/R3/R4/R6/R7 ticks vec %0d", v), ticks_seen, int'(VEC[v].exp_ticks));
         chk(done_seen == ((VEC[v].exp_ticks != 0) ? 1 : 0),
             $sformatf("R10 done count vec %0d", v), done_seen, (VEC[v].exp_ticks != 0) ? 1 : 0);
         chk(clr_seen == int'(VEC[v].exp_clr), $sformatf("R5 clear req vec %0d", v),
             clr_seen, int'(VEC[v].exp_clr));
         chk(flash_on == 1'b0, $sformatf("R2 flash off after vec %0d", v), int'(flash_on), 0);
      end

      // R3: a short strobe pulse in edge mode still gives the full cap
      strobe_level_sel = 1'b0; dur_code = 4'd0; charge_gate_bypass = 1'b0; eoc_flag = 1'b1;
      amb_sense_en = 1'b0; amb_zone = 2'b00;
      repeat (4) cyc(); clear_counts();
      strobe_pin = 1'b1; repeat (4) cyc(); strobe_pin = 1'b0;
      wait_done(2000); repeat (4) cyc();
      chk(ticks_seen == 16, "R3 short strobe full length", ticks_seen, 16);

      // R4: level mode, release before the cap
      strobe_level_sel = 1'b1; dur_code = 4'd15;
      repeat (4) cyc(); clear_counts();
      strobe_pin = 1'b1;
      for (int n = 0; n < 3000 && ticks_seen < 10; n++) cyc();
      strobe_pin = 1'b0;
      repeat (30) cyc();
      chk(flash_on == 1'b0, "R4 level release ends flash", int'(flash_on), 0);
      chk(ticks_seen >= 10 && ticks_seen <= 11, "R4 level release tick count", ticks_seen, 10);
      chk(done_seen == 1, "R4 level release done", done_seen, 1);

      // R9: triggers during a flash are ignored
      strobe_level_sel = 1'b0; dur_code = 4'd1;
      repeat (4) cyc(); clear_counts();
      sw_flash_bit = 1'b1;
      for (int n = 0; n < 3000 && ticks_seen < 10; n++) cyc();
      sw_flash_bit = 1'b0; strobe_pin = 1'b1;
      repeat (3) cyc();
      sw_flash_bit = 1'b1;
      wait_done(3000);
      sw_flash_bit = 1'b0; strobe_pin = 1'b0;
      repeat (40) cyc();
      chk(ticks_seen == 32, "R9 retrigger keeps cap", ticks_seen, 32);
      chk(done_seen == 1, "R9 single completion", done_seen, 1);
      chk(clr_seen == 1, "R5 source stays software", clr_seen, 1);

      // R9: a trigger in the ending cycle is ignored
      dur_code = 4'd0;
      repeat (4) cyc(); clear_counts();
      sw_flash_bit = 1'b1; cyc(); sw_flash_bit = 1'b0;
      for (int n = 0; n < 3000 && ticks_seen < 16; n++) cyc();
      sw_flash_bit = 1'b1;
      repeat (20) cyc();
      chk(flash_on == 1'b0, "R9 trigger at end ignored", int'(flash_on), 0);
      chk(done_seen == 1, "R9 one completion at end", done_seen, 1);

      // one cycle later the trigger is accepted
      sw_flash_bit = 1'b0; repeat (4) cyc(); clear_counts();
      sw_flash_bit = 1'b1; cyc(); sw_flash_bit = 1'b0;
      for (int n = 0; n < 3000 && ticks_seen < 16; n++) cyc();
      cyc();
      sw_flash_bit = 1'b1; cyc();
      chk(flash_on == 1'b1, "R5 trigger after end accepted", int'(flash_on), 1);
      wait_done(3000); sw_flash_bit = 1'b0; repeat (4) cyc();

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule